// File: doc/BRIEF.md
# Four-leg three-level space-vector switching sequencer

This block turns one switching-period command into gate drive for a four-leg, three-level diode-clamped inverter. The fourth leg sets the neutral. An upstream controller locates the reference vector and solves for dwell times. At each period-start strobe it presents the following:
- a base level triple (x, y, z), each 0 or 1;
- a permutation code that places x, y and z onto legs a, b and c;
- a tetrahedron code;
- four dwell times in clock ticks.

The block turns the tetrahedron code into a list of five candidate states. It plays that list forward across the first half-period and backward across the second, so the period is symmetric. It also drives the four gate bits of every leg.

A candidate state is one of twelve rows. Each row joins one of four phase triples with a neutral-leg level. Every tetrahedron list raises each leg's level at most once, so each half-period costs each leg at most one commutation. The first dwell is shared between the first state and the fifth state, because both give the same output vector. Each phase-to-neutral difference is also output, and it takes one of five values.

Top module: `svm4_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets every leg to level 1. Every gate nibble becomes 0110, every phase difference becomes 0, both error flags clear, and the legs stay at level 1 until a period is accepted.
- R2: Each leg's gate nibble is {sw1, sw2, sw3, sw4}. Level 2 gives 1100, level 1 gives 0110 and level 0 gives 0011. `gates` packs the nibbles as {a, b, c, d}, and `leg_lvl` packs the 2-bit levels as {a, b, c, d}.
- R3: Candidate row r (1 to 12) uses triple q = (r-1)/3 and neutral level (r-1) mod 3.
  - The triples are q=0 (x,y,z), q=1 (x+1,y,z), q=2 (x+1,y+1,z) and q=3 (x+1,y+1,z+1).
  - Permutation codes give (a,b,c) as follows: 0 (x,y,z), 1 (x,z,y), 2 (y,x,z), 3 (y,z,x), 4 (z,x,y), 5 (z,y,x).
- R4: Tetrahedron codes select five rows in play order:
  - 1: 1,4,7,10,11
  - 2: 1,4,7,8,11
  - 3: 1,4,5,8,11
  - 4: 1,2,5,8,11
  - 0 (the 4+ case): 2,5,8,11,12
  - 5: 2,5,8,9,12
  - 6: 2,5,6,9,12
  - 7: 2,3,6,9,12
- R5: The period is 2*HALF ticks. Tick 0 shows on the outputs one clock after the accepted strobe edge. At tick k < HALF the state is chosen by these consecutive spans:
  - state 1 for d0 - floor(d0/2) ticks;
  - state 2 for d1 ticks;
  - state 3 for d2 ticks;
  - state 4 for d3 ticks;
  - state 5 for floor(d0/2) ticks plus any ticks left over in the half.
- R6: Tick k with HALF <= k < 2*HALF shows the same state as tick 2*HALF-1-k. The period then repeats from tick 0 with the same latched command.
- R7: Within one half-period each leg's level moves in one direction only. It does not fall in the first half and does not rise in the second half.
- R8: Inputs are taken only on a clock edge with `start` high. An accepted strobe restarts the period at tick 0, even in the middle of a period. Outputs do not change on the strobe edge itself, and input changes without a strobe have no effect.
- R9: If d0+d1+d2+d3 > HALF, `err_dwell` is set until the next strobe. The previously latched command is kept and replayed from tick 0. If no command has been accepted since reset, the legs stay at level 1.
- R10: If any of x, y or z is 2 or more, or the permutation code is 6 or 7, `err_req` is set until the next strobe and the legs freeze at their present levels. A later accepted strobe resumes the sequence at tick 0.
- R11: `ph_diff` packs {a-d, b-d, c-d}. Each field is a 3-bit two's-complement leg-minus-neutral level in the range -2 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Period-start strobe |
| base_x | input | 2 | Base level x |
| base_y | input | 2 | Base level y |
| base_z | input | 2 | Base level z |
| map_sel | input | 3 | Permutation of x, y, z onto legs a, b, c |
| sub_sel | input | 3 | Tetrahedron code (0 means the 4+ case) |
| dur0 | input | TW | Shared dwell of states 1 and 5, in ticks |
| dur1 | input | TW | Dwell of state 2 |
| dur2 | input | TW | Dwell of state 3 |
| dur3 | input | TW | Dwell of state 4 |
| gates | output | 16 | Gate nibbles {a, b, c, d} |
| leg_lvl | output | 8 | Leg levels {a, b, c, d} |
| ph_diff | output | 9 | Signed leg-minus-neutral levels {a, b, c} |
| err_dwell | output | 1 | Dwell sum exceeded the half-period |
| err_req | output | 1 | Base level or permutation code out of range |

## Verification
The hardest cases to reach from the ports are those where an error strobe lands on a sequence that is already running. One case is a dwell-sum error that must replay the old command from tick 0. The other is an invalid level that must freeze the legs in the middle of a half. The stimulus reaches both by sending a bad strobe after a good period has run part way. It then follows the freeze with a second bad strobe and a valid one. Random commands with restarts in mid-period, and input changes between strobes, then cover the sequence tables against a bench model that rebuilds each row from its triple and neutral indices.

// File: rtl/svm4_pkg.sv
package svm4_pkg;

  typedef logic [1:0] lvl_t;

  typedef struct packed {
    lvl_t       x;
    lvl_t       y;
    lvl_t       z;
    logic [2:0] perm;
    logic [2:0] tet;
  } cmd_t;

  // gate nibble {sw1,sw2,sw3,sw4} for one leg level
  function automatic logic [3:0] lvl_gates(input lvl_t l);
    case (l)
      2'd2:    return 4'b1100;
      2'd1:    return 4'b0110;
      default: return 4'b0011;
    endcase
  endfunction

  // a command is usable when every raised level stays within 0..2
  function automatic logic cmd_ok(input cmd_t c);
    return (c.x < 2'd2) && (c.y < 2'd2) && (c.z < 2'd2) && (c.perm < 3'd6);
  endfunction

  // candidate row (1..12) played in position slot (0..4) for a tetrahedron code
  function automatic logic [3:0] pick_row(input logic [2:0] tet, input logic [2:0] slot);
    logic [19:0] lst;
    case (tet)
      3'd1:    lst = {4'd1, 4'd4, 4'd7, 4'd10, 4'd11};
      3'd2:    lst = {4'd1, 4'd4, 4'd7, 4'd8,  4'd11};
      3'd3:    lst = {4'd1, 4'd4, 4'd5, 4'd8,  4'd11};
      3'd4:    lst = {4'd1, 4'd2, 4'd5, 4'd8,  4'd11};
      3'd5:    lst = {4'd2, 4'd5, 4'd8, 4'd9,  4'd12};
      3'd6:    lst = {4'd2, 4'd5, 4'd6, 4'd9,  4'd12};
      3'd7:    lst = {4'd2, 4'd3, 4'd6, 4'd9,  4'd12};
      default: lst = {4'd2, 4'd5, 4'd8, 4'd11, 4'd12};
    endcase
    return lst[(4 - int'(slot)) * 4 +: 4];
  endfunction

  // leg levels {a,b,c,d} of candidate row r
  function automatic logic [7:0] row_legs(input cmd_t c, input logic [3:0] r);
    logic [3:0] r0;
    logic [1:0] q;
    lvl_t       nl, xv, yv, zv, la, lb, lc;
    r0 = r - 4'd1;
    q  = 2'(r0 / 4'd3);
    nl = 2'(r0 % 4'd3);
    xv = c.x + {1'b0, q != 2'd0};
    yv = c.y + {1'b0, q >= 2'd2};
    zv = c.z + {1'b0, q == 2'd3};
    case (c.perm)
      3'd1:    {la, lb, lc} = {xv, zv, yv};
      3'd2:    {la, lb, lc} = {yv, xv, zv};
      3'd3:    {la, lb, lc} = {yv, zv, xv};
      3'd4:    {la, lb, lc} = {zv, xv, yv};
      3'd5:    {la, lb, lc} = {zv, yv, xv};
      default: {la, lb, lc} = {xv, yv, zv};
    endcase
    return {la, lb, lc, nl};
  endfunction

endpackage

// File: rtl/svm4_timer.sv
module svm4_timer #(
  parameter int TW   = 6,
  parameter int HALF = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          adv,
  input  logic [TW-1:0] d0,
  input  logic [TW-1:0] d1,
  input  logic [TW-1:0] d2,
  input  logic [TW-1:0] d3,
  output logic [2:0]    slot,
  output logic          in_second,
  output logic          at_zero
);
  localparam int PER = 2 * HALF;
  localparam int CW  = $clog2(PER);
  localparam int SW  = (CW > TW + 2) ? CW : TW + 2;

  logic [CW-1:0] cnt;
  logic [SW-1:0] u, e1, e2, e3, e4;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (adv)        cnt <= (cnt == CW'(PER - 1)) ? '0 : cnt + 1'b1;
  end

  assign at_zero   = (cnt == '0);
  assign in_second = SW'(cnt) >= SW'(HALF);
  // fold the second half onto the first so both halves share one boundary set
  assign u  = in_second ? SW'(PER - 1) - SW'(cnt) : SW'(cnt);
  assign e1 = SW'(d0) - SW'(d0 >> 1);
  assign e2 = e1 + SW'(d1);
  assign e3 = e2 + SW'(d2);
  assign e4 = e3 + SW'(d3);

  always_comb begin
    if      (u < e1) slot = 3'd0;
    else if (u < e2) slot = 3'd1;
    else if (u < e3) slot = 3'd2;
    else if (u < e4) slot = 3'd3;
    else             slot = 3'd4;
  end
endmodule

// File: rtl/svm4_rows.sv
module svm4_rows
  import svm4_pkg::*;
(
  input  cmd_t        cmd,
  input  logic [2:0]  slot,
  output logic [7:0]  legs
);
  logic [3:0] row;
  assign row  = pick_row(cmd.tet, slot);
  assign legs = row_legs(cmd, row);
endmodule

// File: rtl/svm4_seq.sv
module svm4_seq
  import svm4_pkg::*;
#(
  parameter int TW   = 6,
  parameter int HALF = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    base_x,
  input  logic [1:0]    base_y,
  input  logic [1:0]    base_z,
  input  logic [2:0]    map_sel,
  input  logic [2:0]    sub_sel,
  input  logic [TW-1:0] dur0,
  input  logic [TW-1:0] dur1,
  input  logic [TW-1:0] dur2,
  input  logic [TW-1:0] dur3,
  output logic [15:0]   gates,
  output logic [7:0]    leg_lvl,
  output logic [8:0]    ph_diff,
  output logic          err_dwell,
  output logic          err_req
);
  localparam int SW = TW + 3;

  cmd_t          cmd_in, cmd_q;
  logic [TW-1:0] dq0, dq1, dq2, dq3;
  logic          run, req_good, dw_good, accept;
  logic [SW-1:0] dsum;
  logic [2:0]    slot;
  logic          in_second, at_zero;
  logic [7:0]    nxt_legs, leg_q;
  // events brought out for the checker
  logic          upd_q, first_q, half_q;

  assign cmd_in   = '{x: base_x, y: base_y, z: base_z, perm: map_sel, tet: sub_sel};
  assign req_good = cmd_ok(cmd_in);
  assign dsum     = SW'(dur0) + SW'(dur1) + SW'(dur2) + SW'(dur3);
  assign dw_good  = dsum <= SW'(HALF);
  assign accept   = start && req_good;

  svm4_timer #(.TW(TW), .HALF(HALF)) u_timer (
    .clk(clk), .rst(rst), .restart(accept), .adv(run && !start),
    .d0(dq0), .d1(dq1), .d2(dq2), .d3(dq3),
    .slot(slot), .in_second(in_second), .at_zero(at_zero)
  );

  svm4_rows u_rows (.cmd(cmd_q), .slot(slot), .legs(nxt_legs));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      {dq0, dq1, dq2, dq3} <= '0;
      run       <= 1'b0;
      err_dwell <= 1'b0;
      err_req   <= 1'b0;
      leg_q     <= 8'b01_01_01_01;
      upd_q     <= 1'b0;
      first_q   <= 1'b0;
      half_q    <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (start) begin
        err_req   <= !req_good;
        err_dwell <= !dw_good;
        if (!req_good) begin
          run <= 1'b0;
        end else if (dw_good) begin
          cmd_q <= cmd_in;
          {dq0, dq1, dq2, dq3} <= {dur0, dur1, dur2, dur3};
          run   <= 1'b1;
        end
      end else if (run) begin
        leg_q   <= nxt_legs;
        upd_q   <= 1'b1;
        first_q <= at_zero;
        half_q  <= in_second;
      end
    end
  end

  assign leg_lvl = leg_q;

  for (genvar g = 0; g < 4; g++) begin : g_gate
    assign gates[4*g +: 4] = lvl_gates(leg_q[2*g +: 2]);
  end

  for (genvar g = 0; g < 3; g++) begin : g_phase
    assign ph_diff[3*g +: 3] = {1'b0, leg_q[2*(g+1) +: 2]} - {1'b0, leg_q[1:0]};
  end
endmodule

// File: rtl/svm4_chk.sv
module svm4_chk
  import svm4_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [7:0] leg_q,
  input logic       upd_q,
  input logic       first_q,
  input logic       half_q,
  input logic       err_req,
  input logic       err_dwell,
  input cmd_t       cmd_q
);
  // R1
  reset_level_chk: assert property (@(posedge clk)
    $past(rst) |-> (leg_q == 8'b01_01_01_01) && !err_req && !err_dwell);

  // R7
  rise_first_half_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_q && !first_q && !half_q) |->
      (leg_q[7:6] >= $past(leg_q[7:6])) && (leg_q[5:4] >= $past(leg_q[5:4])) &&
      (leg_q[3:2] >= $past(leg_q[3:2])) && (leg_q[1:0] >= $past(leg_q[1:0])));

  // R7
  fall_second_half_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_q && half_q) |->
      (leg_q[7:6] <= $past(leg_q[7:6])) && (leg_q[5:4] <= $past(leg_q[5:4])) &&
      (leg_q[3:2] <= $past(leg_q[3:2])) && (leg_q[1:0] <= $past(leg_q[1:0])));

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_req |-> $stable(leg_q));

  // R8
  cmd_only_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(cmd_q));
endmodule

bind svm4_seq svm4_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .leg_q(leg_q), .upd_q(upd_q),
  .first_q(first_q), .half_q(half_q), .err_req(err_req),
  .err_dwell(err_dwell), .cmd_q(cmd_q)
);

// File: tb/svm4_seq_test.sv
module svm4_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW   = 6;
  localparam int HALF = 40;
  localparam int PER  = 2 * HALF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    base_x = '0, base_y = '0, base_z = '0;
  logic [2:0]    map_sel = '0, sub_sel = '0;
  logic [TW-1:0] dur0 = '0, dur1 = '0, dur2 = '0, dur3 = '0;
  logic [15:0]   gates;
  logic [7:0]    leg_lvl;
  logic [8:0]    ph_diff;
  logic          err_dwell, err_req;

  int total = 0;
  int bad   = 0;

  // bench model of the latched command
  int m_x, m_y, m_z, m_map, m_sub;
  int m_d[4];
  bit m_cfg    = 0;
  bit m_frozen = 0;
  logic [7:0] last_exp = 8'h55;

  int rowtab[8][5] = '{'{2,5,8,11,12}, '{1,4,7,10,11}, '{1,4,7,8,11}, '{1,4,5,8,11},
                       '{1,2,5,8,11}, '{2,5,8,9,12},  '{2,5,6,9,12}, '{2,3,6,9,12}};
  int ptab[6][3]   = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};

  svm4_seq #(.TW(TW), .HALF(HALF)) uut (
    .clk(clk), .rst(rst), .start(start), .base_x(base_x), .base_y(base_y),
    .base_z(base_z), .map_sel(map_sel), .sub_sel(sub_sel), .dur0(dur0),
    .dur1(dur1), .dur2(dur2), .dur3(dur3), .gates(gates), .leg_lvl(leg_lvl),
    .ph_diff(ph_diff), .err_dwell(err_dwell), .err_req(err_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input int k);
    int u, s, acc, row, q, nl;
    int tv[3];
    u = (k < HALF) ? k : PER - 1 - k;
    acc = m_d[0] - m_d[0] / 2;
    s = 0;
    if (u >= acc) begin
      s = 4;
      for (int i = 1; i < 4; i++) begin
        acc += m_d[i];
        if (u < acc && s == 4) s = i;
      end
      // leftover ticks of the half stay on state 5
      if (s == 4 && u < acc) s = 3;
    end
    row = rowtab[m_sub][s];
    q  = (row - 1) / 3;
    nl = (row - 1) % 3;
    tv[0] = m_x + ((q > 0) ? 1 : 0);
    tv[1] = m_y + ((q > 1) ? 1 : 0);
    tv[2] = m_z + ((q > 2) ? 1 : 0);
    return {2'(tv[ptab[m_map][0]]), 2'(tv[ptab[m_map][1]]), 2'(tv[ptab[m_map][2]]), 2'(nl)};
  endfunction

  function automatic logic [3:0] exp_gate(input logic [1:0] l);
    return (l == 2'd2) ? 4'hC : (l == 2'd1) ? 4'h6 : 4'h3;
  endfunction

  task automatic check_out(input string tag, input logic [7:0] e);
    logic [8:0] ep;
    chk(tag, leg_lvl, e);
    chk("R2 gates", gates, {exp_gate(e[7:6]), exp_gate(e[5:4]), exp_gate(e[3:2]), exp_gate(e[1:0])});
    ep = {3'(e[7:6] - e[1:0]), 3'(e[5:4] - e[1:0]), 3'(e[3:2] - e[1:0])};
    chk("R11 phase diff", ph_diff, ep);
  endtask

  task automatic strobe(input int x, y, z, mp, sb, a0, a1, a2, a3);
    bit rq, dw;
    base_x = 2'(x); base_y = 2'(y); base_z = 2'(z);
    map_sel = 3'(mp); sub_sel = 3'(sb);
    dur0 = TW'(a0); dur1 = TW'(a1); dur2 = TW'(a2); dur3 = TW'(a3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rq = (x < 2) && (y < 2) && (z < 2) && (mp < 6);
    dw = (a0 + a1 + a2 + a3) <= HALF;
    chk("R8 strobe edge hold", leg_lvl, last_exp);
    chk("R10 err_req", err_req, !rq);
    chk("R9 err_dwell", err_dwell, !dw);
    if (!rq) m_frozen = 1;
    else if (dw) begin
      m_x = x; m_y = y; m_z = z; m_map = mp; m_sub = sb;
      m_d = '{a0, a1, a2, a3};
      m_cfg = 1; m_frozen = 0;
    end
  endtask

  // watch n ticks from tick 0; at tick scr the input pins change without a strobe
  task automatic watch(input int n, input int scr);
    logic [7:0] e, prev;
    prev = last_exp;
    for (int k = 0; k < n; k++) begin
      if (k == scr) begin
        base_x = 2'($urandom); base_y = 2'($urandom); base_z = 2'($urandom);
        map_sel = 3'($urandom); sub_sel = 3'($urandom);
        dur0 = TW'($urandom); dur1 = TW'($urandom);
      end
      @(negedge clk);
      if (m_frozen || !m_cfg) begin
        e = last_exp;
        check_out("R10 frozen", e);
      end else begin
        e = model(k % PER);
        check_out(((k % PER) < HALF) ? "R3 R4 R5 sequence" : "R3 R4 R6 mirror", e);
        if ((k % PER) != 0) begin
          for (int g = 0; g < 4; g++) begin
            if ((k % PER) < HALF) chk("R7 rise", leg_lvl[2*g +: 2] >= prev[2*g +: 2], 1);
            else                  chk("R7 fall", leg_lvl[2*g +: 2] <= prev[2*g +: 2], 1);
          end
        end
      end
      prev = leg_lvl;
      last_exp = e;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 legs", leg_lvl, 8'h55);
    chk("R1 gates", gates, 16'h6666);
    chk("R1 phase", ph_diff, 9'd0);
    chk("R1 errs", {err_req, err_dwell}, 2'b00);
    // R9 dwell overflow before any command: legs remain at level 1
    strobe(0, 0, 0, 0, 1, 30, 20, 0, 0);
    watch(5, -1);
    // odd shared dwell, full period plus repeat, pins scrambled mid-period (R5 R6 R8)
    strobe(0, 0, 0, 0, 1, 7, 10, 12, 6);
    watch(PER + 5, 15);
    // 4+ case restarted in mid-period by another strobe (R4 R8)
    strobe(1, 0, 1, 3, 0, 4, 9, 9, 9);
    watch(25, -1);
    strobe(0, 1, 0, 5, 7, 3, 8, 2, 11);
    watch(PER, -1);
    // zero dwells: state 5 for the whole half
    strobe(1, 1, 0, 2, 4, 0, 0, 0, 0);
    watch(PER, -1);
    // sum equal to the half period is accepted
    strobe(0, 1, 1, 4, 2, 10, 10, 10, 10);
    watch(PER, -1);
    // sum one over: previous command replayed (R9)
    strobe(1, 1, 1, 1, 6, 11, 10, 10, 10);
    watch(PER, -1);
    // invalid level freezes legs in mid-sequence (R10)
    strobe(0, 0, 1, 0, 3, 9, 9, 9, 9);
    watch(17, -1);
    strobe(2, 0, 0, 0, 3, 1, 1, 1, 1);
    watch(30, -1);
    strobe(0, 0, 0, 6, 3, 1, 1, 1, 1);
    watch(10, -1);
    strobe(1, 0, 0, 1, 5, 5, 6, 7, 8);
    watch(PER, -1);
    // constrained random commands with occasional faults
    for (int it = 0; it < 40; it++) begin
      int kind, n;
      kind = int'($urandom % 8);
      n = 20 + int'($urandom % (PER + 10));
      if (kind == 0)
        strobe(int'($urandom % 2), 0, 1, int'($urandom % 6), int'($urandom % 8),
               30 + int'($urandom % 10), 15, 1, 0);
      else if (kind == 1)
        strobe(2 + int'($urandom % 2), int'($urandom % 2), int'($urandom % 2),
               int'($urandom % 8), int'($urandom % 8), 2, 2, 2, 2);
      else
        strobe(int'($urandom % 2), int'($urandom % 2), int'($urandom % 2),
               int'($urandom % 6), int'($urandom % 8), int'($urandom % 11),
               int'($urandom % 11), int'($urandom % 11), int'($urandom % 11));
      watch(n, (kind == 2) ? n / 2 : -1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule